// File: doc/BRIEF.md
# Transaction-Layer Packet Receive Framer and Header Decoder

This block sits on the receive side of a transaction layer. It takes a stream of 32-bit double words, with a start strobe on the first word of a packet and an end strobe on the last. As each word arrives, it works out which part of the packet the word belongs to: a leading prefix word, a header word, a payload word or a trailing digest word. It works this out from fields of the first header word, so the block needs no side information about the packet.

Once the whole header has been captured, the common header fields come out on a sideband bus for one cycle, together with the raw header words and the number of prefix words skipped. The next stages route each payload word to a data output and tag a digest word on a separate output. If a packet ends too early or runs past the length its header implies, the block raises a one-cycle framing error and goes back to waiting for a start strobe.

Top module: `tlp_rx_framer`

## Requirements
- R1: After reset every pulse output (`hdr_valid`, `pay_valid`, `pay_last`, `dig_valid`, `frame_err`) is low, and while the framer is idle, words without `in_sop` produce no output at all.
- R2: A leading word whose bits 31:29 equal 100 is a prefix. It is skipped and counted. Any number of prefixes is allowed, and the count saturates at all ones of `hdr_prefix_cnt`.
- R3: Bits 31:29 of header word 0 select the header size. 000 and 010 mean 3 words, and 001 and 011 mean 4 words. `hdr_valid` pulses one cycle after the last header word is accepted. `hdr_words` holds header word k at bits 32k+31:32k, and word 3 is zero for a 3-word header.
- R4: Header word 0 decodes as follows: type from bits 28:24 to `hdr_type`, traffic class from bits 22:20 to `hdr_tc`, and attributes from bits 13:12 to `hdr_attr`.
- R5: The length field in bits 9:0 counts payload double words. A field of 0 means 1024 words, and any other value means that many words (so 1023 means 1023). It is shown on the 11-bit `hdr_len_dw`.
- R6: A payload follows only when bit 30 of word 0 is set. Each payload word appears on `pay_data` with `pay_valid` one cycle after it is accepted, and `pay_last` marks the final one.
- R7: When the digest bit (bit 15) is set, one more word follows the payload, or follows the header if there is no payload. That word appears on `dig_data` with `dig_valid`, and never on the payload output.
- R8: The 2-bit translation field (bits 11:10: 00 default, 01 request, 10 translated) appears on `hdr_at`. The reserved value 11 also sets `hdr_at_warn`.
- R9: The poison bit (bit 14) and the digest bit are forwarded as `hdr_poison` and `hdr_digest`.
- R10: `frame_err` pulses for one cycle, one cycle after any of these words: a word carrying `in_eop` before the expected last word; an expected last word without `in_eop`; an `in_sop` inside a packet; or a leading word with bits 31:29 of 101, 110 or 111. The framer then goes idle, and the offending word gives no other output.
- R11: Each accepted word gives at most one output event. With back-to-back input, the first payload word appears in the cycle right after `hdr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input double word |
| hdr_valid | output | 1 | One-cycle pulse: header fields valid |
| hdr_fmt | output | 3 | Format field |
| hdr_type | output | 5 | Type field |
| hdr_tc | output | 3 | Traffic class |
| hdr_digest | output | 1 | Digest word follows |
| hdr_poison | output | 1 | Payload poisoned |
| hdr_attr | output | 2 | Attribute bits |
| hdr_at | output | 2 | Address translation field |
| hdr_at_warn | output | 1 | Translation field holds reserved value |
| hdr_len_dw | output | 11 | Payload length in double words (1 to 1024) |
| hdr_prefix_cnt | output | PFX_CNT_W | Prefix words skipped (saturating) |
| hdr_words | output | 128 | Raw header words, word 0 in the low bits |
| pay_valid | output | 1 | Payload word valid |
| pay_data | output | 32 | Payload word |
| pay_last | output | 1 | Final payload word |
| dig_valid | output | 1 | Digest word valid |
| dig_data | output | 32 | Digest word |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
Every result is registered once. `hdr_valid` is due one cycle after the last header word, each payload or digest output one cycle after its word, and `frame_err` one cycle after the offending word. The bench drives words on falling edges and counts pulses on the falling edges in between, so every one-cycle pulse is seen exactly once. Totals, sums and captured fields are compared only after idle cycles following the packet. The cycle in which the header pulse was seen is recorded, and the bench checks that the first payload word lands exactly one cycle later.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = 10;
    localparam int CNT_W      = LEN_W + 1;
    localparam int MAX_HDR_DW = 4;
    localparam int HIDX_W     = $clog2(MAX_HDR_DW);

    typedef enum logic [2:0] {
        FMT_H3_NODATA = 3'b000,
        FMT_H4_NODATA = 3'b001,
        FMT_H3_DATA   = 3'b010,
        FMT_H4_DATA   = 3'b011,
        FMT_PREFIX    = 3'b100
    } fmt_e;

    typedef enum logic [1:0] {
        AT_DEFAULT = 2'b00,
        AT_REQUEST = 2'b01,
        AT_DONE    = 2'b10,
        AT_RSVD    = 2'b11
    } at_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_PAY,
        ST_DIG
    } rx_state_e;

    typedef struct packed {
        logic [2:0]       fmt;
        logic [4:0]       kind;
        logic [2:0]       tc;
        logic             digest;
        logic             poison;
        logic [1:0]       attr;
        logic [1:0]       at;
        logic             at_warn;
        logic [CNT_W-1:0] len_dw;
    } hdr_info_t;

    function automatic logic [CNT_W-1:0] len_to_dw(input logic [LEN_W-1:0] f);
        return (f == '0) ? CNT_W'(1 << LEN_W) : {1'b0, f};
    endfunction

    function automatic logic [HIDX_W-1:0] last_hdr_idx(input logic [2:0] fmt);
        return fmt[0] ? HIDX_W'(3) : HIDX_W'(2);
    endfunction

    function automatic logic fmt_has_data(input logic [2:0] fmt);
        return fmt[1];
    endfunction

endpackage

// File: rtl/tlp_hdr_decode.sv
module tlp_hdr_decode
    import tlp_rx_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output hdr_info_t         info_o,
    output logic              is_prefix_o,
    output logic              is_header_o
);

    logic unused_rsvd_bits;
    assign unused_rsvd_bits = ^{word_i[23], word_i[19:16]};

    always_comb begin
        info_o.fmt     = word_i[31:29];
        info_o.kind    = word_i[28:24];
        info_o.tc      = word_i[22:20];
        info_o.digest  = word_i[15];
        info_o.poison  = word_i[14];
        info_o.attr    = word_i[13:12];
        info_o.at      = word_i[11:10];
        info_o.at_warn = (word_i[11:10] == AT_RSVD);
        info_o.len_dw  = len_to_dw(word_i[LEN_W-1:0]);
    end

    assign is_prefix_o = (word_i[31:29] == FMT_PREFIX);
    assign is_header_o = ~word_i[31];

endmodule

// File: rtl/tlp_rx_fsm.sv
module tlp_rx_fsm
    import tlp_rx_pkg::*;
#(
    parameter int PFX_CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic                         in_eop,
    input  logic [WORD_W-1:0]            in_data,
    input  hdr_info_t                    dec_info,
    input  logic                         dec_is_prefix,
    input  logic                         dec_is_header,
    output logic                         hdr_valid_o,
    output hdr_info_t                    hdr_o,
    output logic [PFX_CNT_W-1:0]         pfx_cnt_o,
    output logic [MAX_HDR_DW*WORD_W-1:0] hdr_words_o,
    output logic                         pay_valid_o,
    output logic [WORD_W-1:0]            pay_data_o,
    output logic                         pay_last_o,
    output logic                         dig_valid_o,
    output logic [WORD_W-1:0]            dig_data_o,
    output logic                         err_o
);

    localparam logic [PFX_CNT_W-1:0] PFX_MAX = {PFX_CNT_W{1'b1}};

    rx_state_e                              st_q;
    hdr_info_t                              hdr_q;
    logic [MAX_HDR_DW-1:0][WORD_W-1:0]      words_q;
    logic [HIDX_W-1:0]                      hidx_q;
    logic [CNT_W-1:0]                       rem_q;
    logic [PFX_CNT_W-1:0]                   pfx_q;

    logic lead_slot, sop_bad, hdr_last, tail_exp, pay_final;

    // A leading word is either the start word or any word while prefixes are still arriving
    assign lead_slot = (st_q == ST_IDLE && in_sop) || (st_q == ST_LEAD && !in_sop);
    assign sop_bad   = in_sop && (st_q != ST_IDLE);
    assign hdr_last  = (hidx_q == last_hdr_idx(hdr_q.fmt));
    assign tail_exp  = fmt_has_data(hdr_q.fmt) || hdr_q.digest;
    assign pay_final = (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            hdr_q       <= '0;
            words_q     <= '0;
            hidx_q      <= '0;
            rem_q       <= '0;
            pfx_q       <= '0;
            hdr_valid_o <= 1'b0;
            pay_valid_o <= 1'b0;
            pay_data_o  <= '0;
            pay_last_o  <= 1'b0;
            dig_valid_o <= 1'b0;
            dig_data_o  <= '0;
            err_o       <= 1'b0;
        end else begin
            hdr_valid_o <= 1'b0;
            pay_valid_o <= 1'b0;
            pay_last_o  <= 1'b0;
            dig_valid_o <= 1'b0;
            err_o       <= 1'b0;
            if (in_valid) begin
                if (sop_bad) begin
                    err_o <= 1'b1;
                    st_q  <= ST_IDLE;
                end else begin
                    case (st_q)
                        ST_IDLE, ST_LEAD: begin
                            if (lead_slot) begin
                                if (in_eop || !(dec_is_prefix || dec_is_header)) begin
                                    err_o <= 1'b1;
                                    st_q  <= ST_IDLE;
                                end else if (dec_is_prefix) begin
                                    if (st_q == ST_IDLE)
                                        pfx_q <= PFX_CNT_W'(1);
                                    else if (pfx_q != PFX_MAX)
                                        pfx_q <= pfx_q + 1'b1;
                                    st_q <= ST_LEAD;
                                end else begin
                                    if (st_q == ST_IDLE)
                                        pfx_q <= '0;
                                    hdr_q      <= dec_info;
                                    words_q    <= '0;
                                    words_q[0] <= in_data;
                                    hidx_q     <= HIDX_W'(1);
                                    st_q       <= ST_HDR;
                                end
                            end
                        end
                        ST_HDR: begin
                            words_q[hidx_q] <= in_data;
                            if (!hdr_last) begin
                                if (in_eop) begin
                                    err_o <= 1'b1;
                                    st_q  <= ST_IDLE;
                                end else begin
                                    hidx_q <= hidx_q + 1'b1;
                                end
                            end else if (in_eop == tail_exp) begin
                                err_o <= 1'b1;
                                st_q  <= ST_IDLE;
                            end else begin
                                hdr_valid_o <= 1'b1;
                                rem_q       <= hdr_q.len_dw;
                                if (fmt_has_data(hdr_q.fmt))
                                    st_q <= ST_PAY;
                                else if (hdr_q.digest)
                                    st_q <= ST_DIG;
                                else
                                    st_q <= ST_IDLE;
                            end
                        end
                        ST_PAY: begin
                            if ((!pay_final && in_eop) || (pay_final && (in_eop == hdr_q.digest))) begin
                                err_o <= 1'b1;
                                st_q  <= ST_IDLE;
                            end else begin
                                pay_valid_o <= 1'b1;
                                pay_data_o  <= in_data;
                                pay_last_o  <= pay_final;
                                rem_q       <= rem_q - 1'b1;
                                if (pay_final)
                                    st_q <= hdr_q.digest ? ST_DIG : ST_IDLE;
                            end
                        end
                        ST_DIG: begin
                            if (!in_eop) begin
                                err_o <= 1'b1;
                            end else begin
                                dig_valid_o <= 1'b1;
                                dig_data_o  <= in_data;
                            end
                            st_q <= ST_IDLE;
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign hdr_o       = hdr_q;
    assign pfx_cnt_o   = pfx_q;
    assign hdr_words_o = words_q;

    // R11: one accepted word yields at most one event
    a_r11_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_valid_o, pay_valid_o, dig_valid_o, err_o}));

    // R10: an error always leaves the framer idle
    a_r10_err_to_idle: assert property (@(posedge clk) disable iff (rst)
        err_o |-> st_q == ST_IDLE);

    // R6: the final payload word leaves the payload segment, others stay in it
    a_r6_last_exits: assert property (@(posedge clk) disable iff (rst)
        (pay_valid_o && pay_last_o) |-> st_q != ST_PAY);
    a_r6_more_follow: assert property (@(posedge clk) disable iff (rst)
        (pay_valid_o && !pay_last_o) |-> st_q == ST_PAY);

    // R7: a digest word closes the packet
    a_r7_digest_closes: assert property (@(posedge clk) disable iff (rst)
        dig_valid_o |-> st_q == ST_IDLE);

    // R5: the remaining payload count stays within 1..1024
    a_r5_rem_range: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PAY) |-> (rem_q != '0 && rem_q <= CNT_W'(1 << LEN_W)));

    // R2: while prefixes are arriving at least one has been counted
    a_r2_prefix_counted: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LEAD) |-> pfx_q != '0);

    // R1: without an input word the sequence does not move
    a_r1_hold_when_idle_input: assert property (@(posedge clk) disable iff (rst)
        (!$past(in_valid) && !$past(rst)) |-> $stable(st_q));

endmodule

// File: rtl/tlp_rx_framer.sv
module tlp_rx_framer
    import tlp_rx_pkg::*;
#(
    parameter int PFX_CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         in_sop,
    input  logic                         in_eop,
    input  logic [WORD_W-1:0]            in_data,
    output logic                         hdr_valid,
    output logic [2:0]                   hdr_fmt,
    output logic [4:0]                   hdr_type,
    output logic [2:0]                   hdr_tc,
    output logic                         hdr_digest,
    output logic                         hdr_poison,
    output logic [1:0]                   hdr_attr,
    output logic [1:0]                   hdr_at,
    output logic                         hdr_at_warn,
    output logic [CNT_W-1:0]             hdr_len_dw,
    output logic [PFX_CNT_W-1:0]         hdr_prefix_cnt,
    output logic [MAX_HDR_DW*WORD_W-1:0] hdr_words,
    output logic                         pay_valid,
    output logic [WORD_W-1:0]            pay_data,
    output logic                         pay_last,
    output logic                         dig_valid,
    output logic [WORD_W-1:0]            dig_data,
    output logic                         frame_err
);

    hdr_info_t dec_info;
    hdr_info_t hdr_info;
    logic      dec_is_prefix;
    logic      dec_is_header;

    tlp_hdr_decode u_decode (
        .word_i      (in_data),
        .info_o      (dec_info),
        .is_prefix_o (dec_is_prefix),
        .is_header_o (dec_is_header)
    );

    tlp_rx_fsm #(.PFX_CNT_W(PFX_CNT_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_sop        (in_sop),
        .in_eop        (in_eop),
        .in_data       (in_data),
        .dec_info      (dec_info),
        .dec_is_prefix (dec_is_prefix),
        .dec_is_header (dec_is_header),
        .hdr_valid_o   (hdr_valid),
        .hdr_o         (hdr_info),
        .pfx_cnt_o     (hdr_prefix_cnt),
        .hdr_words_o   (hdr_words),
        .pay_valid_o   (pay_valid),
        .pay_data_o    (pay_data),
        .pay_last_o    (pay_last),
        .dig_valid_o   (dig_valid),
        .dig_data_o    (dig_data),
        .err_o         (frame_err)
    );

    assign hdr_fmt     = hdr_info.fmt;
    assign hdr_type    = hdr_info.kind;
    assign hdr_tc      = hdr_info.tc;
    assign hdr_digest  = hdr_info.digest;
    assign hdr_poison  = hdr_info.poison;
    assign hdr_attr    = hdr_info.attr;
    assign hdr_at      = hdr_info.at;
    assign hdr_at_warn = hdr_info.at_warn;
    assign hdr_len_dw  = hdr_info.len_dw;

endmodule

// File: tb/sim_tlp_rx_framer.sv
module sim_tlp_rx_framer;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, in_valid, in_sop, in_eop;
    logic [31:0] in_data;
    logic        hdr_valid, hdr_digest, hdr_poison, hdr_at_warn;
    logic [2:0]  hdr_fmt, hdr_tc;
    logic [4:0]  hdr_type;
    logic [1:0]  hdr_attr, hdr_at;
    logic [10:0] hdr_len_dw;
    logic [3:0]  hdr_prefix_cnt;
    logic [127:0] hdr_words;
    logic        pay_valid, pay_last, dig_valid, frame_err;
    logic [31:0] pay_data, dig_data;

    tlp_rx_framer #(.PFX_CNT_W(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_data(in_data), .hdr_valid(hdr_valid), .hdr_fmt(hdr_fmt), .hdr_type(hdr_type),
        .hdr_tc(hdr_tc), .hdr_digest(hdr_digest), .hdr_poison(hdr_poison),
        .hdr_attr(hdr_attr), .hdr_at(hdr_at), .hdr_at_warn(hdr_at_warn),
        .hdr_len_dw(hdr_len_dw), .hdr_prefix_cnt(hdr_prefix_cnt), .hdr_words(hdr_words),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last),
        .dig_valid(dig_valid), .dig_data(dig_data), .frame_err(frame_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Event monitor, sampling on falling edges
    int cyc = 0;
    int m_hdr, m_pay, m_last, m_dig, m_err, m_hdr_cyc, m_pay1_cyc;
    logic [31:0]  m_sum, m_lastdata, m_digdata;
    logic [127:0] m_words;
    logic [2:0]   m_fmt, m_tc;
    logic [4:0]   m_type;
    logic [1:0]   m_attr, m_at;
    logic         m_td, m_ep, m_warn;
    logic [10:0]  m_len;
    logic [3:0]   m_pfx;

    task automatic clr();
        m_hdr = 0; m_pay = 0; m_last = 0; m_dig = 0; m_err = 0;
        m_hdr_cyc = -1; m_pay1_cyc = -1; m_sum = '0; m_lastdata = '0; m_digdata = '0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (hdr_valid) begin
                m_hdr++; m_hdr_cyc = cyc; m_words = hdr_words; m_fmt = hdr_fmt;
                m_tc = hdr_tc; m_type = hdr_type; m_attr = hdr_attr; m_at = hdr_at;
                m_td = hdr_digest; m_ep = hdr_poison; m_warn = hdr_at_warn;
                m_len = hdr_len_dw; m_pfx = hdr_prefix_cnt;
            end
            if (pay_valid) begin
                if (m_pay == 0) m_pay1_cyc = cyc;
                m_pay++; m_sum = m_sum + pay_data;
                if (pay_last) begin m_last++; m_lastdata = pay_data; end
            end
            if (dig_valid) begin m_dig++; m_digdata = dig_data; end
            if (frame_err) m_err++;
        end
    end

    function automatic logic [31:0] mk(input logic [2:0] f, input logic [4:0] t,
            input logic [2:0] tc, input logic td, input logic ep,
            input logic [1:0] attr, input logic [1:0] at, input logic [9:0] len);
        return {f, t, 1'b0, tc, 4'b0000, td, ep, attr, at, len};
    endfunction

    task automatic put(input logic s, input logic e, input logic [31:0] d);
        in_valid = 1'b1; in_sop = s; in_eop = e; in_data = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Builds the packet word list from the requirements; cut>0 ends early, extra adds words
    task automatic send_pkt(input logic [31:0] w0, input int npfx, input int cut,
                            input int extra, input int didx);
        int hdw = w0[29] ? 4 : 3;
        int nd  = w0[30] ? ((w0[9:0] == 0) ? 1024 : int'(w0[9:0])) : 0;
        int ntd = int'(w0[15]);
        int total = npfx + hdw + nd + ntd + extra;
        int last = (cut > 0) ? cut : total;
        for (int k = 0; k < last; k++) begin
            logic [31:0] d;
            if (k < npfx)                      d = {3'b100, 29'(k)};
            else if (k == npfx)                d = w0;
            else if (k < npfx + hdw)           d = 32'hB000_0000 + 32'(k - npfx);
            else if (k < npfx + hdw + nd)      d = 32'hA500_0000 + 32'(k - npfx - hdw);
            else if (k < npfx + hdw + nd + ntd) d = 32'hD16E_0000 + 32'(didx);
            else                               d = 32'hE000_0000 + 32'(k);
            put(k == 0, k == last - 1, d);
        end
        idle(3);
    endtask

    localparam int NV = 7;
    localparam logic [35:0] VEC [NV] = '{
        {mk(3'b000, 5'h00, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1),   4'd0},
        {mk(3'b001, 5'h00, 3'd1, 1'b0, 1'b0, 2'd1, 2'd1, 10'd4),   4'd1},
        {mk(3'b010, 5'h00, 3'd5, 1'b0, 1'b1, 2'd0, 2'd0, 10'd3),   4'd0},
        {mk(3'b011, 5'h0A, 3'd2, 1'b1, 1'b0, 2'd2, 2'd2, 10'd2),   4'd2},
        {mk(3'b010, 5'h00, 3'd7, 1'b0, 1'b0, 2'd3, 2'd3, 10'd0),   4'd0},
        {mk(3'b000, 5'h04, 3'd3, 1'b1, 1'b0, 2'd0, 2'd3, 10'd1023), 4'd0},
        {mk(3'b011, 5'h1B, 3'd6, 1'b1, 1'b1, 2'd1, 2'd0, 10'd1),   4'd3}
    };

    task automatic run_vectors();
        for (int v = 0; v < NV; v++) begin
            logic [31:0] w0 = VEC[v][35:4];
            int np  = int'(VEC[v][3:0]);
            int hdw = w0[29] ? 4 : 3;
            int len = (w0[9:0] == 0) ? 1024 : int'(w0[9:0]);
            int nd  = w0[30] ? len : 0;
            int ntd = int'(w0[15]);
            logic [31:0] esum = '0;
            for (int i = 0; i < nd; i++) esum = esum + 32'hA500_0000 + 32'(i);
            clr();
            send_pkt(w0, np, 0, 0, v);
            chk(m_hdr == 1, "R3", "header pulses", m_hdr, 1);
            chk(m_err == 0, "R10", "no error on good packet", m_err, 0);
            chk(m_fmt == w0[31:29], "R3", "format", m_fmt, w0[31:29]);
            chk(m_words[31:0] == w0, "R3", "header word 0", m_words[31:0], w0);
            chk(m_words[127:96] == ((hdw == 4) ? 32'hB000_0003 : 32'h0), "R3", "header word 3",
                m_words[127:96], (hdw == 4) ? 32'hB000_0003 : 32'h0);
            chk({m_type, m_tc, m_attr} == {w0[28:24], w0[22:20], w0[13:12]}, "R4", "type/tc/attr",
                {m_type, m_tc, m_attr}, {w0[28:24], w0[22:20], w0[13:12]});
            chk(int'(m_len) == len, "R5", "length", m_len, len);
            chk(m_pay == nd, "R6", "payload count", m_pay, nd);
            chk(m_sum == esum, "R6", "payload sum", m_sum, esum);
            chk(m_last == ((nd > 0) ? 1 : 0), "R6", "last flag count", m_last, (nd > 0) ? 1 : 0);
            if (nd > 0) begin
                chk(m_lastdata == 32'hA500_0000 + 32'(nd - 1), "R6", "last payload word",
                    m_lastdata, 32'hA500_0000 + 32'(nd - 1));
                chk(m_pay1_cyc == m_hdr_cyc + 1, "R11", "first payload follows header",
                    m_pay1_cyc, m_hdr_cyc + 1);
            end
            chk(m_dig == ntd, "R7", "digest count", m_dig, ntd);
            if (ntd == 1)
                chk(m_digdata == 32'hD16E_0000 + 32'(v), "R7", "digest word", m_digdata,
                    32'hD16E_0000 + 32'(v));
            chk(m_at == w0[11:10] && m_warn == (w0[11:10] == 2'b11), "R8", "translation/warn",
                {m_at, m_warn}, {w0[11:10], w0[11:10] == 2'b11});
            chk(m_ep == w0[14] && m_td == w0[15], "R9", "poison/digest bits",
                {m_ep, m_td}, {w0[14], w0[15]});
            chk(int'(m_pfx) == np, "R2", "prefix count", m_pfx, np);
        end
    endtask

    task automatic run_all();
        logic [31:0] w;
        // R1 reset state
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({hdr_valid, pay_valid, pay_last, dig_valid, frame_err} == 5'b0, "R1", "pulses after reset",
            {hdr_valid, pay_valid, pay_last, dig_valid, frame_err}, 0);
        // R1 words without start strobe while idle are ignored
        clr();
        put(1'b0, 1'b0, mk(3'b010, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1));
        put(1'b0, 1'b0, 32'h1); put(1'b0, 1'b0, 32'h2); put(1'b0, 1'b1, 32'h3);
        idle(3);
        chk(m_hdr + m_pay + m_dig + m_err == 0, "R1", "idle ignores unframed words",
            m_hdr + m_pay + m_dig + m_err, 0);

        run_vectors();

        // R2 prefix count saturates
        clr();
        send_pkt(mk(3'b000, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1), 20, 0, 0, 0);
        chk(m_hdr == 1 && m_pfx == 4'hF, "R2", "saturated prefix count", m_pfx, 15);

        // R10 early end inside payload
        clr();
        send_pkt(mk(3'b010, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd4), 0, 5, 0, 0);
        chk(m_err == 1, "R10", "early end error pulse", m_err, 1);
        chk(m_pay == 1 && m_hdr == 1, "R10", "early end payload words", m_pay, 1);

        // R10 missing end strobe on a header-only packet
        clr();
        send_pkt(mk(3'b000, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1), 0, 0, 1, 0);
        chk(m_err == 1 && m_hdr == 0, "R10", "overrun error, no header", {m_err, m_hdr}, 32'h1_0);

        // R10 end strobe where a digest was due
        clr();
        send_pkt(mk(3'b010, 5'h0, 3'd0, 1'b1, 1'b0, 2'd0, 2'd0, 10'd1), 0, 4, 0, 0);
        chk(m_err == 1 && m_pay == 0 && m_dig == 0, "R10", "missing digest",
            {m_err, m_pay, m_dig}, 1);

        // R10 reserved leading format
        clr();
        put(1'b1, 1'b0, mk(3'b101, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1));
        put(1'b0, 1'b0, 32'h0); put(1'b0, 1'b1, 32'h0);
        idle(3);
        chk(m_err == 1 && m_hdr == 0, "R10", "bad format", {m_err, m_hdr}, 32'h1_0);

        // R10 end strobe on header word 0
        clr();
        put(1'b1, 1'b1, mk(3'b000, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1));
        idle(3);
        chk(m_err == 1 && m_hdr == 0, "R10", "one-word packet", {m_err, m_hdr}, 32'h1_0);

        // R10 start strobe inside a packet, then recovery
        clr();
        w = mk(3'b001, 5'h0, 3'd0, 1'b0, 1'b0, 2'd0, 2'd0, 10'd1);
        put(1'b1, 1'b0, w); put(1'b0, 1'b0, 32'h5); put(1'b1, 1'b1, 32'h6);
        idle(3);
        chk(m_err == 1 && m_hdr == 0, "R10", "start inside packet", {m_err, m_hdr}, 32'h1_0);
        clr();
        send_pkt(mk(3'b010, 5'h2, 3'd1, 1'b0, 1'b0, 2'd0, 2'd0, 10'd2), 0, 0, 0, 0);
        chk(m_err == 0 && m_hdr == 1 && m_pay == 2, "R10", "recovery after error",
            {m_err, m_hdr, m_pay}, 32'h0_1_2);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(negedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule